// File: doc/BRIEF.md
# Line-Synchronised Clamp Pulse Generator

This block produces the black-level clamp strobe for a video digitiser. It runs in the pixel-clock domain. A horizontal sync input is brought through a two-stage synchroniser. The block then finds the sync trailing edge, whose direction depends on a programmable polarity bit. After that edge it waits a programmed number of pixel periods and holds the clamp strobe high for a second programmed number of pixel periods.

A bypass mode ignores the internal timing altogether. In that mode the strobe follows an external clamp input, which passes through its own synchroniser, and a polarity bit sets whether that input is active high or active low. For each colour channel the block also reports the code the clamp drives toward. Red and blue each have a select bit that picks bottom code 00h or midscale 80h. Green always targets 00h. The analog clamp circuitry sits outside this block.

Top module: `clamp_strobe_gen`

Suggested register start values are a delay of 08h and a duration of 14h (20 pixel periods). They are exported as package constants.

## Requirements
- R1: While `rst` is high, `clamp_out` is 0 and all three target outputs are 00h.
- R2: With `cfg_hs_pol`=0 (falling edge is the active sync edge), the rising edge of `hsync_in` is the trailing edge. `clamp_out` first goes high `cfg_delay`+4 rising clock edges after the first edge that samples the new `hsync_in` level (counting that edge as the first).
- R3: With `cfg_hs_pol`=1 (rising edge active), the falling edge of `hsync_in` is the trailing edge, and the timing is the same as in R2.
- R4: In internal mode, `clamp_out` stays high for exactly `cfg_width` clock cycles per trailing edge, for any delay from 0 to 255.
- R5: A `cfg_width` of 0 produces no clamp pulse.
- R6: A trailing edge that arrives during a pending delay or during an active clamp restarts the sequence, with timing measured from the new edge.
- R7: With `cfg_ext_en`=1, `clamp_out` follows the synchronised external input three clock edges after it changes, and sync edges have no effect.
- R8: With `cfg_ext_pol`=1 the external input is active high. With `cfg_ext_pol`=0 it is active low.
- R9: With `cfg_ext_en`=0, `ext_clamp_in` has no effect on `clamp_out`.
- R10: `red_target` is 80h when `cfg_red_mid`=1 and 00h otherwise. `blue_target` follows `cfg_blue_mid` in the same way. `green_target` is always 00h. Each target is registered with a latency of one clock.
- R11: The leading (active) edge of sync never starts a clamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| ext_clamp_in | input | 1 | External clamp request, asynchronous |
| cfg_hs_pol | input | 1 | 0: falling edge of sync is active, 1: rising edge is active |
| cfg_ext_en | input | 1 | 1 selects the external clamp input |
| cfg_ext_pol | input | 1 | 1: external input is active high, 0: active low |
| cfg_delay | input | CNT_W | Pixel periods from the trailing edge to the clamp start |
| cfg_width | input | CNT_W | Clamp length in pixel periods |
| cfg_red_mid | input | 1 | Red target select |
| cfg_blue_mid | input | 1 | Blue target select |
| clamp_out | output | 1 | Registered clamp strobe |
| red_target | output | CODE_W | Red clamp target code |
| green_target | output | CODE_W | Green clamp target code |
| blue_target | output | CODE_W | Blue clamp target code |

## Verification
The assertions check three things on every cycle:
- A detected trailing edge lasts exactly one cycle.
- A zero width leaves the timer idle, and a new edge immediately reloads the timer into waiting or clamping.
- The strobe stays low in internal mode whenever the timer is idle, and the red and blue targets only ever take the two legal codes.

Exact start latency, pulse length, restart behaviour and external polarity can only be shown by the bench. It sweeps delay, width and sync polarity and compares each cycle against a window computed from the edge time.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  localparam int CNT_W_DEF  = 8;
  localparam int CODE_W_DEF = 8;
  localparam logic [7:0] DELAY_START = 8'h08;
  localparam logic [7:0] WIDTH_START = 8'h14;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ON   = 2'd2
  } clamp_state_e;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= 1'b0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= 1'b0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hs_trail_detect.sv
module hs_trail_detect (
  input  logic clk,
  input  logic rst,
  input  logic hs_sync,
  input  logic cfg_hs_pol,
  output logic trail
);
  logic hs_prev;

  always_ff @(posedge clk) begin
    if (rst) hs_prev <= 1'b0;
    else     hs_prev <= hs_sync;
  end

  // Trailing edge is the opposite of the active edge.
  always_comb begin
    if (cfg_hs_pol) trail = hs_prev & ~hs_sync;
    else            trail = ~hs_prev & hs_sync;
  end

  a_r2_trail_single: assert property (@(posedge clk) disable iff (rst)
    trail |=> !trail);
endmodule

// File: rtl/clamp_timer.sv
module clamp_timer
  import clamp_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trail,
  input  logic [CNT_W-1:0] cfg_delay,
  input  logic [CNT_W-1:0] cfg_width,
  output logic             on
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  clamp_state_e     state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= ZERO;
    end else if (trail) begin
      if (cfg_width == ZERO) begin
        state <= ST_IDLE;
        cnt   <= ZERO;
      end else if (cfg_delay == ZERO) begin
        state <= ST_ON;
        cnt   <= cfg_width - ONE;
      end else begin
        state <= ST_WAIT;
        cnt   <= cfg_delay - ONE;
      end
    end else begin
      case (state)
        ST_WAIT: begin
          if (cnt != ZERO)            cnt <= cnt - ONE;
          else if (cfg_width == ZERO) state <= ST_IDLE;
          else begin
            state <= ST_ON;
            cnt   <= cfg_width - ONE;
          end
        end
        ST_ON: begin
          if (cnt == ZERO) state <= ST_IDLE;
          else             cnt   <= cnt - ONE;
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= ZERO;
        end
      endcase
    end
  end

  assign on = (state == ST_ON);

  a_r5_zero_width: assert property (@(posedge clk) disable iff (rst)
    (trail && cfg_width == ZERO) |=> !on);

  a_r6_restart_load: assert property (@(posedge clk) disable iff (rst)
    (trail && cfg_width != ZERO) |=> (on == $past(cfg_delay == ZERO)));
endmodule

// File: rtl/clamp_strobe_gen.sv
module clamp_strobe_gen
  import clamp_pkg::*;
#(
  parameter int CNT_W       = CNT_W_DEF,
  parameter int CODE_W      = CODE_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_in,
  input  logic              ext_clamp_in,
  input  logic              cfg_hs_pol,
  input  logic              cfg_ext_en,
  input  logic              cfg_ext_pol,
  input  logic [CNT_W-1:0]  cfg_delay,
  input  logic [CNT_W-1:0]  cfg_width,
  input  logic              cfg_red_mid,
  input  logic              cfg_blue_mid,
  output logic              clamp_out,
  output logic [CODE_W-1:0] red_target,
  output logic [CODE_W-1:0] green_target,
  output logic [CODE_W-1:0] blue_target
);
  localparam logic [CODE_W-1:0] CODE_BOT = '0;
  localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic hs_s, ext_s, trail, tmr_on;

  sync_chain #(.STAGES(SYNC_STAGES)) u_hs_sync (
    .clk(clk), .rst(rst), .d(hsync_in), .q(hs_s));

  sync_chain #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .d(ext_clamp_in), .q(ext_s));

  hs_trail_detect u_trail (
    .clk(clk), .rst(rst), .hs_sync(hs_s), .cfg_hs_pol(cfg_hs_pol),
    .trail(trail));

  clamp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .trail(trail), .cfg_delay(cfg_delay),
    .cfg_width(cfg_width), .on(tmr_on));

  always_ff @(posedge clk) begin
    if (rst) begin
      clamp_out    <= 1'b0;
      red_target   <= CODE_BOT;
      green_target <= CODE_BOT;
      blue_target  <= CODE_BOT;
    end else begin
      clamp_out    <= cfg_ext_en ? (ext_s == cfg_ext_pol) : tmr_on;
      red_target   <= cfg_red_mid  ? CODE_MID : CODE_BOT;
      green_target <= CODE_BOT;
      blue_target  <= cfg_blue_mid ? CODE_MID : CODE_BOT;
    end
  end

  a_r9_internal_idle: assert property (@(posedge clk) disable iff (rst)
    (!cfg_ext_en && !tmr_on) |=> !clamp_out);

  a_r10_red_code: assert property (@(posedge clk) disable iff (rst)
    (red_target == CODE_BOT) || (red_target == CODE_MID));

  a_r10_blue_code: assert property (@(posedge clk) disable iff (rst)
    (blue_target == CODE_BOT) || (blue_target == CODE_MID));
endmodule

// File: tb/clamp_strobe_gen_test.sv
// Latency: a sync level change is first sampled at posedge 1.
// The edge reaches the timer at posedge 3, the ON state begins
// at posedge 3+delay, and clamp_out rises at posedge 4+delay.
// The external path takes 3 posedges: two synchroniser stages
// and the output register.
module clamp_strobe_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_in = 1'b1, ext_clamp_in = 1'b0;
  logic cfg_hs_pol = 1'b0, cfg_ext_en = 1'b0, cfg_ext_pol = 1'b1;
  logic [7:0] cfg_delay = 8'h08, cfg_width = 8'h14;
  logic cfg_red_mid = 1'b0, cfg_blue_mid = 1'b0;
  logic clamp_out;
  logic [7:0] red_target, green_target, blue_target;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clamp_strobe_gen uut (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .ext_clamp_in(ext_clamp_in),
    .cfg_hs_pol(cfg_hs_pol), .cfg_ext_en(cfg_ext_en),
    .cfg_ext_pol(cfg_ext_pol), .cfg_delay(cfg_delay),
    .cfg_width(cfg_width), .cfg_red_mid(cfg_red_mid),
    .cfg_blue_mid(cfg_blue_mid), .clamp_out(clamp_out),
    .red_target(red_target), .green_target(green_target),
    .blue_target(blue_target));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle(input bit pol);
    @(negedge clk);
    cfg_hs_pol = pol;
    hsync_in   = ~pol;
    repeat (50) @(negedge clk);
  endtask

  task automatic run_line(input int d, input int w, input bit pol);
    @(negedge clk);
    cfg_delay = 8'(d);
    cfg_width = 8'(w);
    settle(pol);
    hsync_in = pol;
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      chk("R11 leading edge", clamp_out, 0);
    end
    hsync_in = ~pol;
    for (int j = 1; j <= d + w + 8; j++) begin
      @(negedge clk);
      if (w == 0)   chk("R5 zero width", clamp_out, 0);
      else if (pol) chk("R3 R4 falling trail window", clamp_out,
                        int'(j >= d + 4 && j < d + 4 + w));
      else          chk("R2 R4 rising trail window", clamp_out,
                        int'(j >= d + 4 && j < d + 4 + w));
    end
  endtask

  task automatic ext_run(input bit p);
    logic [15:0] pat;
    logic hist [0:15];
    pat = 16'b1011_0010_0111_0001;
    @(negedge clk);
    cfg_ext_en = 1'b1;
    cfg_ext_pol = p;
    ext_clamp_in = ~p;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (i >= 3) chk("R7 R8 external follow", clamp_out, int'(hist[i-3] == p));
      hist[i] = pat[i];
      ext_clamp_in = pat[i];
      hsync_in = (i % 4) < 2;
    end
    @(negedge clk);
    cfg_ext_en = 1'b0;
    ext_clamp_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset clamp", clamp_out, 0);
    chk("R1 reset red", red_target, 0);
    chk("R1 reset green", green_target, 0);
    chk("R1 reset blue", blue_target, 0);
    rst = 1'b0;

    for (int pi = 0; pi < 2; pi++)
      for (int di = 0; di < 5; di++)
        for (int wi = 0; wi < 4; wi++) begin
          int dl [5] = '{0, 1, 2, 5, 8};
          int wl [4] = '{0, 1, 3, 20};
          run_line(dl[di], wl[wi], pi[0]);
        end
    run_line(255, 2, 1'b1);

    // R6: restart during pending delay (delay 4, width 6, rising active)
    @(negedge clk); cfg_delay = 8'd4; cfg_width = 8'd6;
    settle(1'b1);
    hsync_in = 1'b1;
    repeat (2) @(negedge clk);
    hsync_in = 1'b0;
    for (int j = 1; j <= 3; j++) begin
      @(negedge clk);
      chk("R6 pending before restart", clamp_out, 0);
      if (j == 2) hsync_in = 1'b1;
      if (j == 3) hsync_in = 1'b0;
    end
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      chk("R6 restart from delay", clamp_out, int'(k >= 8 && k < 14));
    end

    // R6: restart during active clamp (delay 0, width 10, falling active)
    @(negedge clk); cfg_delay = 8'd0; cfg_width = 8'd10;
    settle(1'b0);
    hsync_in = 1'b0;
    repeat (2) @(negedge clk);
    hsync_in = 1'b1;
    for (int j = 1; j <= 7; j++) begin
      @(negedge clk);
      chk("R6 active before restart", clamp_out, int'(j >= 4));
      if (j == 6) hsync_in = 1'b0;
      if (j == 7) hsync_in = 1'b1;
    end
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      chk("R6 restart while clamping", clamp_out, int'(k < 14));
    end

    // R7, R8: external mode, both senses, sync toggling ignored
    @(negedge clk); cfg_delay = 8'd1; cfg_width = 8'd5;
    ext_run(1'b1);
    settle(1'b0);
    ext_run(1'b0);
    settle(1'b0);

    // R9: external input ignored in internal mode
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R9 external ignored", clamp_out, 0);
      ext_clamp_in = i[0];
      cfg_ext_pol = i[1];
    end

    // R10: target codes
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      cfg_red_mid = m[0];
      cfg_blue_mid = m[1];
      @(negedge clk);
      chk("R10 red target", red_target, m[0] ? 8'h80 : 8'h00);
      chk("R10 green target", green_target, 8'h00);
      chk("R10 blue target", blue_target, m[1] ? 8'h80 : 8'h00);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule